// File: doc/BRIEF.md
# Vector Load Lane Unit

This unit carries out vector loads into a bank of 64-bit vector registers. It supports three load kinds. A multi-register load fills one to four consecutive registers with whole 64-bit words from memory. A lane-insert load reads one 8-, 16- or 32-bit element into a single lane and leaves the other lanes unchanged. A broadcast load reads one element and writes a copy of it into every lane of the register.

A decoded command enters through a valid/ready handshake. The command carries the kind, the element size, the first register, the register count, the lane, the base address and a writeback flag. The unit sends one read request per register or element to a simple memory port. It then waits for the response, which may take any number of cycles, and merges the returned bytes into the register bank. The bank has an extra combinational read port for inspection. When the command is complete, a one-cycle done pulse returns the base address, advanced by the bytes moved if writeback was requested, together with an error flag for commands that were rejected.

Top module: `vec_lane_load`

## Requirements
- R1: Kind code 0 (multi) with count n in 1..4 loads register first+k from the 8 bytes at base+8k, for k = 0..n-1. The byte at the lowest address lands in bits 7:0 and the highest in bits 63:56.
- R2: Kind code 1 (lane insert) with size code s (0 = 8-bit, 1 = 16-bit, 2 = 32-bit) writes the element from base into bits [lane*W +: W], where W = 8<<s. Every other bit of the register keeps its old value.
- R3: Kind code 2 (broadcast) writes a copy of the element from base into every W-bit lane of the target register.
- R4: Each register or element costs exactly one single-cycle request on mem_req_o. The request carries mem_addr_o and mem_size_o (log2 of the byte count: 3 for multi, s for element loads). The data is taken from the low bytes of mem_rdata_i in the cycle mem_rvalid_i is high, after a latency of one or more cycles.
- R5: With writeback set, addr_o equals base plus the bytes moved (8n for multi, 1<<s for element loads). With writeback clear, addr_o equals base.
- R6: An element load with size code 3, or with a lane of 8>>s or more, is rejected: err_o is 1, no memory request is issued, no register changes and addr_o equals base.
- R7: A multi load with count 0, a count above 4, or first+count above 32 is rejected in the same way as in R6.
- R8: cmd_ready_o is high only when idle. It drops the cycle after a command is accepted and stays low until the done pulse.
- R9: done_o is high for exactly one cycle. For an accepted command it comes in the cycle after the last register write. For a rejected command it comes in the cycle after acceptance. Kind code 3 is always rejected.
- R10: While rst_ni is low, every register reads zero, cmd_ready_o is high and done_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command valid |
| cmd_ready_o | output | 1 | Unit idle, command accepted |
| cmd_mode_i | input | 2 | Load kind: 0 multi, 1 lane insert, 2 broadcast |
| cmd_size_i | input | 2 | Element size code: 0 byte, 1 half, 2 word |
| cmd_reg_i | input | 5 | First target register |
| cmd_cnt_i | input | 3 | Register count for multi loads |
| cmd_lane_i | input | 3 | Lane for lane insert |
| cmd_addr_i | input | 32 | Base byte address |
| cmd_wb_i | input | 1 | Post-increment enable |
| mem_req_o | output | 1 | Read request strobe |
| mem_addr_o | output | 32 | Read byte address |
| mem_size_o | output | 2 | log2 of read byte count |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 64 | Read data, lowest address in low byte |
| done_o | output | 1 | Command finished |
| err_o | output | 1 | Command rejected (with done_o) |
| addr_o | output | 32 | Updated base address (with done_o) |
| rd_idx_i | input | 5 | Inspection read index |
| rd_data_o | output | 64 | Inspection read data |

## Verification
The memory holds a known ascending byte pattern, so a swapped byte order or a wrong lane offset shows up at once. The canonical sequence is a whole-register fill, then a byte insert into lane 5, then a byte broadcast. This sequence separates the three write-mask shapes on one register. Half-word and word inserts at the top legal lane, plus broadcasts of every width, exercise the size-dependent offsets. A four-register fill that ends exactly at the last register, combined with memory latencies from one to four cycles, checks address stepping and the timing of the done pulse. Commands that just miss each limit (count past the end, lane one too high, reserved size, reserved kind) check that a rejected command leaves every register untouched.

// File: rtl/vll_pkg.sv
`timescale 1ns/1ps
package vll_pkg;
  typedef enum logic [1:0] {
    LD_MULTI = 2'd0,
    LD_LANE  = 2'd1,
    LD_ALL   = 2'd2,
    LD_RSVD  = 2'd3
  } ld_mode_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_REQ  = 2'd1,
    S_WAIT = 2'd2,
    S_RESP = 2'd3
  } ld_state_e;

  localparam int unsigned VREG_W   = 64;
  localparam int unsigned VREG_B   = VREG_W / 8;
  localparam int unsigned SIZE_RSVD = 3;
endpackage

// File: rtl/vll_regfile.sv
`timescale 1ns/1ps
module vll_regfile #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned RIDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [RIDX_W-1:0] widx_i,
  input  logic [63:0]       wdata_i,
  input  logic [7:0]        wmask_i,
  input  logic [RIDX_W-1:0] ridx_i,
  output logic [63:0]       rdata_o
);
  logic [63:0] regs_q [NUM_REGS];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        regs_q[r] <= '0;
      end else if (we_i && (int'(widx_i) == r)) begin
        for (int b = 0; b < 8; b++) begin
          if (wmask_i[b]) regs_q[r][b*8 +: 8] <= wdata_i[b*8 +: 8];
        end
      end
    end
  end

  assign rdata_o = regs_q[ridx_i];

  // every write must touch at least one lane byte
  assert_write_has_bytes_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> (wmask_i != 8'h00));
endmodule

// File: rtl/vll_lane_fmt.sv
`timescale 1ns/1ps
module vll_lane_fmt
  import vll_pkg::*;
(
  input  logic [1:0]  mode_i,
  input  logic [1:0]  size_i,
  input  logic [2:0]  lane_i,
  input  logic [63:0] rdata_i,
  output logic [63:0] wdata_o,
  output logic [7:0]  wmask_o
);
  ld_mode_e mode;
  logic [2:0] el_mask;

  assign mode    = ld_mode_e'(mode_i);
  assign el_mask = 3'((4'd1 << size_i) - 4'd1);

  // per destination byte: source byte within element and owning lane
  for (genvar b = 0; b < 8; b++) begin : g_byte
    logic [2:0] src_b;
    logic [2:0] lane_of;
    always_comb begin
      src_b   = 3'(b) & el_mask;
      lane_of = 3'(b) >> size_i;
      unique case (mode)
        LD_MULTI: begin
          wdata_o[b*8 +: 8] = rdata_i[b*8 +: 8];
          wmask_o[b]        = 1'b1;
        end
        LD_LANE: begin
          wdata_o[b*8 +: 8] = rdata_i[src_b*8 +: 8];
          wmask_o[b]        = (lane_of == lane_i);
        end
        LD_ALL: begin
          wdata_o[b*8 +: 8] = rdata_i[src_b*8 +: 8];
          wmask_o[b]        = 1'b1;
        end
        default: begin
          wdata_o[b*8 +: 8] = 8'h00;
          wmask_o[b]        = 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/vll_ctrl.sv
`timescale 1ns/1ps
module vll_ctrl
  import vll_pkg::*;
#(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned MAX_REGS = 4,
  parameter int unsigned RIDX_W   = $clog2(NUM_REGS),
  parameter int unsigned CNT_W    = $clog2(MAX_REGS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [1:0]        cmd_mode_i,
  input  logic [1:0]        cmd_size_i,
  input  logic [RIDX_W-1:0] cmd_reg_i,
  input  logic [CNT_W-1:0]  cmd_cnt_i,
  input  logic [2:0]        cmd_lane_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic              cmd_wb_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [1:0]        mem_size_o,
  input  logic              mem_rvalid_i,
  output logic              wr_en_o,
  output logic [RIDX_W-1:0] wr_idx_o,
  output logic [1:0]        mode_o,
  output logic [1:0]        size_o,
  output logic [2:0]        lane_o,
  output logic              done_o,
  output logic              err_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(VREG_B);

  ld_state_e         state_q;
  ld_mode_e          mode_q, cmd_mode;
  logic [1:0]        size_q;
  logic [2:0]        lane_q;
  logic [RIDX_W-1:0] idx_q;
  logic [CNT_W-1:0]  left_q;
  logic [ADDR_W-1:0] cur_q, fin_q;
  logic              err_q;

  logic              accept, lane_ok, multi_ok, cmd_err;
  logic [3:0]        lane_lim;
  logic [ADDR_W-1:0] xfer_bytes;

  assign cmd_mode = ld_mode_e'(cmd_mode_i);
  assign accept   = cmd_valid_i && (state_q == S_IDLE);

  always_comb begin
    lane_lim = 4'd8 >> cmd_size_i;
    lane_ok  = (int'(cmd_size_i) != SIZE_RSVD) &&
               ((cmd_mode == LD_ALL) || ({1'b0, cmd_lane_i} < lane_lim));
    multi_ok = (cmd_cnt_i != '0) && (int'(cmd_cnt_i) <= MAX_REGS) &&
               ((int'(cmd_reg_i) + int'(cmd_cnt_i)) <= NUM_REGS);
    unique case (cmd_mode)
      LD_MULTI:       cmd_err = !multi_ok;
      LD_LANE, LD_ALL: cmd_err = !lane_ok;
      default:        cmd_err = 1'b1;
    endcase
    xfer_bytes = (cmd_mode == LD_MULTI) ? (ADDR_W'(cmd_cnt_i) << 3)
                                        : (ADDR_W'(1) << cmd_size_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      mode_q  <= LD_MULTI;
      size_q  <= '0;
      lane_q  <= '0;
      idx_q   <= '0;
      left_q  <= '0;
      cur_q   <= '0;
      fin_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (accept) begin
          mode_q  <= cmd_mode;
          size_q  <= cmd_size_i;
          lane_q  <= cmd_lane_i;
          idx_q   <= cmd_reg_i;
          left_q  <= (cmd_mode == LD_MULTI) ? cmd_cnt_i : CNT_W'(1);
          cur_q   <= cmd_addr_i;
          fin_q   <= (cmd_wb_i && !cmd_err) ? cmd_addr_i + xfer_bytes : cmd_addr_i;
          err_q   <= cmd_err;
          state_q <= cmd_err ? S_RESP : S_REQ;
        end
        S_REQ:  state_q <= S_WAIT;
        S_WAIT: if (mem_rvalid_i) begin
          if (left_q == CNT_W'(1)) begin
            state_q <= S_RESP;
          end else begin
            left_q  <= left_q - CNT_W'(1);
            idx_q   <= idx_q + RIDX_W'(1);
            cur_q   <= cur_q + WORD_STEP;
            state_q <= S_REQ;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign cmd_ready_o = (state_q == S_IDLE);
  assign mem_req_o   = (state_q == S_REQ);
  assign mem_addr_o  = cur_q;
  assign mem_size_o  = (mode_q == LD_MULTI) ? 2'd3 : size_q;
  assign wr_en_o     = (state_q == S_WAIT) && mem_rvalid_i;
  assign wr_idx_o    = idx_q;
  assign mode_o      = mode_q;
  assign size_o      = size_q;
  assign lane_o      = lane_q;
  assign done_o      = (state_q == S_RESP);
  assign err_o       = (state_q == S_RESP) && err_q;
  assign addr_o      = fin_q;

  assert_ready_drops_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o) |=> !cmd_ready_o);
  assert_ready_after_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> cmd_ready_o);
  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_single_req_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);
  assert_no_req_rejected_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !err_q);
endmodule

// File: rtl/vec_lane_load.sv
`timescale 1ns/1ps
module vec_lane_load #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned MAX_REGS = 4,
  localparam int unsigned RIDX_W  = $clog2(NUM_REGS),
  localparam int unsigned CNT_W   = $clog2(MAX_REGS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [1:0]        cmd_mode_i,
  input  logic [1:0]        cmd_size_i,
  input  logic [RIDX_W-1:0] cmd_reg_i,
  input  logic [CNT_W-1:0]  cmd_cnt_i,
  input  logic [2:0]        cmd_lane_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic              cmd_wb_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [1:0]        mem_size_o,
  input  logic              mem_rvalid_i,
  input  logic [63:0]       mem_rdata_i,
  output logic              done_o,
  output logic              err_o,
  output logic [ADDR_W-1:0] addr_o,
  input  logic [RIDX_W-1:0] rd_idx_i,
  output logic [63:0]       rd_data_o
);
  logic              wr_en;
  logic [RIDX_W-1:0] wr_idx;
  logic [1:0]        mode, size;
  logic [2:0]        lane;
  logic [63:0]       wdata;
  logic [7:0]        wmask;

  vll_ctrl #(
    .NUM_REGS (NUM_REGS),
    .ADDR_W   (ADDR_W),
    .MAX_REGS (MAX_REGS)
  ) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_valid_i  (cmd_valid_i),
    .cmd_ready_o  (cmd_ready_o),
    .cmd_mode_i   (cmd_mode_i),
    .cmd_size_i   (cmd_size_i),
    .cmd_reg_i    (cmd_reg_i),
    .cmd_cnt_i    (cmd_cnt_i),
    .cmd_lane_i   (cmd_lane_i),
    .cmd_addr_i   (cmd_addr_i),
    .cmd_wb_i     (cmd_wb_i),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_size_o   (mem_size_o),
    .mem_rvalid_i (mem_rvalid_i),
    .wr_en_o      (wr_en),
    .wr_idx_o     (wr_idx),
    .mode_o       (mode),
    .size_o       (size),
    .lane_o       (lane),
    .done_o       (done_o),
    .err_o        (err_o),
    .addr_o       (addr_o)
  );

  vll_lane_fmt u_fmt (
    .mode_i  (mode),
    .size_i  (size),
    .lane_i  (lane),
    .rdata_i (mem_rdata_i),
    .wdata_o (wdata),
    .wmask_o (wmask)
  );

  vll_regfile #(
    .NUM_REGS (NUM_REGS)
  ) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en),
    .widx_i  (wr_idx),
    .wdata_i (wdata),
    .wmask_i (wmask),
    .ridx_i  (rd_idx_i),
    .rdata_o (rd_data_o)
  );
endmodule

// File: tb/vec_lane_load_tb.sv
`timescale 1ns/1ps
module vec_lane_load_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic        cmd_ready_o;
  logic [1:0]  cmd_mode_i = '0;
  logic [1:0]  cmd_size_i = '0;
  logic [4:0]  cmd_reg_i = '0;
  logic [2:0]  cmd_cnt_i = '0;
  logic [2:0]  cmd_lane_i = '0;
  logic [31:0] cmd_addr_i = '0;
  logic        cmd_wb_i = 1'b0;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic [1:0]  mem_size_o;
  logic        mem_rvalid_i = 1'b0;
  logic [63:0] mem_rdata_i = '0;
  logic        done_o, err_o;
  logic [31:0] addr_o;
  logic [4:0]  rd_idx_i = '0;
  logic [63:0] rd_data_o;

  logic [63:0] ref_rf [32];
  logic [7:0]  mem [256];
  int checks = 0;
  int fails  = 0;

  always #4 clk_i = ~clk_i;

  vec_lane_load u_dut (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_ready_o, .cmd_mode_i, .cmd_size_i,
    .cmd_reg_i, .cmd_cnt_i, .cmd_lane_i, .cmd_addr_i, .cmd_wb_i,
    .mem_req_o, .mem_addr_o, .mem_size_o, .mem_rvalid_i, .mem_rdata_i,
    .done_o, .err_o, .addr_o, .rd_idx_i, .rd_data_o
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mem8(input int a);
    logic [63:0] r;
    for (int j = 0; j < 8; j++) r[j*8 +: 8] = mem[(a + j) & 255];
    return r;
  endfunction

  task automatic check_rf(input string tag);
    for (int r = 0; r < 32; r++) begin
      rd_idx_i = 5'(r);
      #1;
      chk(tag, rd_data_o, ref_rf[r]);
    end
  endtask

  task automatic run(input int mode, input int size, input int rg, input int cnt,
                     input int lane, input int addr, input bit wb, input int lat);
    bit e, finished, last;
    int nreq, k, pend, ebytes, lim;
    logic [31:0] exp_addr;
    string tag;
    lim = 8 >> size;
    e = (mode == 3) ||
        (mode == 0 && (cnt == 0 || cnt > 4 || rg + cnt > 32)) ||
        (mode == 1 && (size == 3 || lane >= lim)) ||
        (mode == 2 && size == 3);
    nreq = e ? 0 : ((mode == 0) ? cnt : 1);
    ebytes = 1 << size;
    exp_addr = (wb && !e) ? 32'(addr + ((mode == 0) ? cnt * 8 : ebytes)) : 32'(addr);
    tag = e ? "R6 R7 rejected leaves regs" :
          (mode == 0) ? "R1 multi fill" : (mode == 1) ? "R2 lane insert" : "R3 broadcast";

    @(negedge clk_i);
    chk("R8 ready when idle", cmd_ready_o, 1);
    cmd_valid_i = 1'b1;
    cmd_mode_i = 2'(mode); cmd_size_i = 2'(size); cmd_reg_i = 5'(rg);
    cmd_cnt_i = 3'(cnt); cmd_lane_i = 3'(lane); cmd_addr_i = 32'(addr); cmd_wb_i = wb;
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    finished = 0; last = 0; k = 0; pend = 0;
    for (int it = 0; it < 200; it++) begin
      if (it > 0) @(negedge clk_i);
      if (done_o) begin
        chk("R9 done timing", e ? (it == 0) : last, 1);
        chk("R6 R7 R9 err flag", err_o, e);
        chk("R5 returned address", addr_o, exp_addr);
        finished = 1;
        break;
      end
      chk("R8 ready low while busy", cmd_ready_o, 0);
      last = 0;
      mem_rvalid_i = 1'b0;
      mem_rdata_i = 64'hDEAD_BEEF_0BAD_F00D;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          mem_rvalid_i = 1'b1;
          mem_rdata_i = mem8((mode == 0) ? addr + 8 * (k - 1) : addr);
          if (k == nreq) last = 1;
        end
      end
      if (mem_req_o) begin
        chk("R4 request expected", k < nreq, 1);
        chk("R4 request address", mem_addr_o, 32'((mode == 0) ? addr + 8 * k : addr));
        chk("R4 request size", mem_size_o, (mode == 0) ? 2'd3 : 2'(size));
        k++;
        pend = lat;
      end
    end
    mem_rvalid_i = 1'b0;
    if (!finished) chk("R9 done never seen", 0, 1);
    chk("R4 request count", k, nreq);
    if (!e) begin
      if (mode == 0) begin
        for (int q = 0; q < cnt; q++) ref_rf[rg + q] = mem8(addr + 8 * q);
      end else if (mode == 1) begin
        for (int b = 0; b < ebytes; b++) ref_rf[rg][(lane * ebytes + b) * 8 +: 8] = mem[(addr + b) & 255];
      end else begin
        for (int p = 0; p < 8; p++) ref_rf[rg][p * 8 +: 8] = mem[(addr + (p % ebytes)) & 255];
      end
    end
    check_rf(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog R9 actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 5) & 255);
    mem[0] = 8'h01; mem[1] = 8'h23; mem[2] = 8'h45; mem[3] = 8'h67;
    mem[4] = 8'h89; mem[5] = 8'hAB; mem[6] = 8'hCD; mem[7] = 8'hEF;
    for (int r = 0; r < 32; r++) ref_rf[r] = '0;

    repeat (3) @(negedge clk_i);
    chk("R10 ready in reset", cmd_ready_o, 1);
    chk("R10 done low in reset", done_o, 0);
    check_rf("R10 regs clear");
    rst_ni = 1'b1;

    // canonical sequence on register 0
    run(0, 0, 0, 1, 0, 0, 1, 1);
    rd_idx_i = 5'd0; #1;
    chk("R1 little-endian word", rd_data_o, 64'hEFCDAB89_67452301);
    run(1, 0, 0, 0, 5, 0, 1, 2);
    rd_idx_i = 5'd0; #1;
    chk("R2 byte into lane 5", rd_data_o, 64'hEFCD0189_67452301);
    run(2, 0, 0, 0, 0, 1, 1, 1);
    rd_idx_i = 5'd0; #1;
    chk("R3 byte broadcast", rd_data_o, 64'h23232323_23232323);

    run(0, 0, 28, 4, 0, 16, 1, 3);    // ends exactly at register 31
    run(0, 0, 10, 2, 0, 100, 0, 4);   // no writeback
    run(1, 1, 5, 0, 3, 40, 0, 2);     // top half-word lane
    run(1, 2, 5, 0, 1, 77, 1, 1);     // upper word lane
    run(1, 1, 6, 0, 0, 9, 1, 1);
    run(2, 1, 7, 0, 0, 50, 1, 2);
    run(2, 2, 8, 0, 0, 61, 1, 3);
    run(1, 0, 9, 0, 7, 200, 1, 1);

    // rejected commands
    run(0, 0, 30, 3, 0, 8, 1, 1);     // R7 past last register
    run(0, 0, 3, 0, 0, 8, 1, 1);      // R7 zero count
    run(0, 0, 3, 5, 0, 8, 1, 1);      // R7 count above four
    run(1, 1, 5, 0, 4, 8, 1, 1);      // R6 lane too high for half
    run(1, 2, 5, 0, 2, 8, 1, 1);      // R6 lane too high for word
    run(1, 3, 5, 0, 0, 8, 1, 1);      // R6 reserved size
    run(2, 3, 5, 0, 0, 8, 1, 1);      // R6 reserved size broadcast
    run(3, 0, 5, 1, 0, 8, 1, 1);      // R9 reserved kind

    run(0, 0, 0, 1, 0, 24, 1, 1);     // still working after errors
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule